// File: doc/BRIEF.md
# Scan Register Access Bridge

The bridge sits between a host that issues 64-bit memory-mapped reads and writes and an internal bus of scan registers. Each host access carries a byte address. The bridge takes a 32-bit register index from address bits [34:3]. On the downstream side it presents that index as a byte address, which is the index shifted left by three.

A fixed group of housekeeping indices is handled inside the bridge and never reaches the downstream port. Reads of the chip identification index return a configured constant. Reads of a set of diagnostic, poll and accelerator indices return zero. Writes to the identification index and to another fixed set of indices are absorbed. Every other aligned access is forwarded. The downstream port holds each request until it acknowledges it, and it returns read data together with an error flag. Host data passes through unchanged as a big-endian 64-bit word.

Each finished transaction ORs bits into a sticky status word. Bit 0 is DONE and bit 1 is FAIL. Bits accumulate until the host pulses the clear strobe or reset is applied. The controller has three states. IDLE accepts a request and moves to RESP for a local or misaligned access, or to FWD for a forwarded one. FWD waits for the acknowledge and then moves to RESP. RESP presents the response for one cycle and always returns to IDLE.

Top module: `scan_bridge`

## Requirements
- R1: The downstream byte address equals host address bits [34:3] followed by three zero bits. `dn_write` and `dn_wdata` carry the host's direction and data.
- R2: A read of index 0xF000F returns `CHIP_ID_VAL`. It is not forwarded, and the status word becomes 2'b01 (DONE only).
- R3: Reads of these indices return zero and are not forwarded: 0x18002, 0x1010C00, 0x1010C03, 0x1020013, 0x1020014, 0xF0033, 0xF0034, 0x2020007, 0x2020009, 0x202000F, 0x2013F01, 0x2013F05, 0x2013028, 0x201302A, 0x2013801, 0x2013802, 0x2010828, 0x201082A, 0x2010841, 0x2010842, 0x4010828, 0x401082A, 0x4010841 and 0x4010842.
- R4: Writes to these indices are absorbed, with DONE only and no forwarding: 0xF000F, 0x1010C00 through 0x1010C05, the four poll indices, 0x2020007, 0x2020009, 0x202000F and the twelve accelerator indices of R3. A write to 0xF000F leaves later reads unchanged.
- R5: Every aligned access that is not local is forwarded, including a read of a write-only-absorbed index and a write to a read-only-zero index. `dn_req` and `dn_addr` stay constant until `dn_ack`.
- R6: A forwarded read without error returns `dn_rdata` and sets DONE only. A forwarded or local write returns zero data.
- R7: A forwarded access that completes with `dn_err` sets DONE and FAIL (2'b11). A failed read returns zero.
- R8: An access whose address bits [2:0] are not zero is not forwarded. It returns zero and sets DONE and FAIL.
- R9: Status bits are sticky, so a later successful access does not clear FAIL.
- R10: A pulse on `stat_clear` zeroes the status word. If a transaction completes in the same cycle as the clear, its bits still take effect.
- R11: Only one access is outstanding at a time. `host_req_ready` is low from acceptance until the response cycle ends. `host_rsp_valid` is a one-cycle pulse.
- R12: After reset, `stat_word` is 0, `host_req_ready` is 1, and `host_rsp_valid` and `dn_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req_valid | input | 1 | Host request present |
| host_req_ready | output | 1 | Bridge can accept a request (IDLE) |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_addr | input | 35 | Host byte address |
| host_req_wdata | input | 64 | Host write data |
| host_rsp_valid | output | 1 | One-cycle response pulse |
| host_rsp_rdata | output | 64 | Read data (zero for writes and failures) |
| dn_req | output | 1 | Downstream request, held until acknowledged |
| dn_write | output | 1 | Downstream direction |
| dn_addr | output | 35 | Downstream byte address (index shifted left by 3) |
| dn_wdata | output | 64 | Downstream write data |
| dn_ack | input | 1 | Downstream completion |
| dn_rdata | input | 64 | Downstream read data, valid with `dn_ack` |
| dn_err | input | 1 | Downstream error, valid with `dn_ack` |
| stat_clear | input | 1 | Clear strobe for the status word |
| stat_word | output | 2 | Sticky status: bit 0 DONE, bit 1 FAIL |

## Verification
A local or misaligned request is accepted at clock edge E0. From the next cycle, `host_rsp_valid`, the read data and the updated `stat_word` can be observed, and the pulse is gone one cycle later. A forwarded request raises `dn_req` in the cycle after E0, and it stays high through any wait. The response and the status appear in the cycle after the edge that samples `dn_ack`. The bench drives inputs on falling edges and samples on the following falling edge, one register stage after the edge that launched the change.

// File: rtl/scan_bridge_pkg.sv
package scan_bridge_pkg;
    localparam int IDX_W   = 32;
    localparam int DATA_W  = 64;
    localparam int ADDR_W  = IDX_W + 3;
    localparam int STAT_W  = 2;
    localparam int STAT_DONE_BIT = 0;
    localparam int STAT_FAIL_BIT = 1;

    localparam logic [IDX_W-1:0] IDX_CHIP_ID = 32'h000F_000F;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_RESP = 2'd2
    } br_state_e;
endpackage

// File: rtl/scan_local_filter.sv
module scan_local_filter
    import scan_bridge_pkg::*;
#(
    parameter logic [DATA_W-1:0] CHIP_ID_VAL = 64'h120D_A049_0000_0000
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              write_i,
    output logic              hit_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic accel_idx;
    logic poll_idx;
    logic diag_idx;

    always_comb begin
        unique case (idx_i)
            32'h0201_3028, 32'h0201_302A, 32'h0201_3801, 32'h0201_3802,
            32'h0201_0828, 32'h0201_082A, 32'h0201_0841, 32'h0201_0842,
            32'h0401_0828, 32'h0401_082A, 32'h0401_0841, 32'h0401_0842:
                accel_idx = 1'b1;
            default: accel_idx = 1'b0;
        endcase
        unique case (idx_i)
            32'h0102_0013, 32'h0102_0014, 32'h000F_0033, 32'h000F_0034:
                poll_idx = 1'b1;
            default: poll_idx = 1'b0;
        endcase
        unique case (idx_i)
            32'h0202_0007, 32'h0202_0009, 32'h0202_000F:
                diag_idx = 1'b1;
            default: diag_idx = 1'b0;
        endcase
    end

    always_comb begin
        hit_o   = 1'b0;
        rdata_o = '0;
        if (write_i) begin
            hit_o = accel_idx || poll_idx || diag_idx || (idx_i == IDX_CHIP_ID)
                 || (idx_i >= 32'h0101_0C00 && idx_i <= 32'h0101_0C05);
        end else if (idx_i == IDX_CHIP_ID) begin
            hit_o   = 1'b1;
            rdata_o = CHIP_ID_VAL;
        end else begin
            hit_o = accel_idx || poll_idx || diag_idx
                 || (idx_i == 32'h0001_8002) || (idx_i == 32'h0101_0C00)
                 || (idx_i == 32'h0101_0C03) || (idx_i == 32'h0201_3F01)
                 || (idx_i == 32'h0201_3F05);
        end
    end
endmodule

// File: rtl/scan_status_word.sv
module scan_status_word
    import scan_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              set_done_i,
    input  logic              set_fail_i,
    output logic [STAT_W-1:0] stat_o
);
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] set_bits;

    always_comb begin
        set_bits = '0;
        set_bits[STAT_DONE_BIT] = set_done_i;
        set_bits[STAT_FAIL_BIT] = set_fail_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (clr_i ? '0 : stat_q) | set_bits;
    end

    assign stat_o = stat_q;

    // R9
    sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/scan_bridge.sv
module scan_bridge
    import scan_bridge_pkg::*;
#(
    parameter logic [DATA_W-1:0] CHIP_ID_VAL = 64'h120D_A049_0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req_valid,
    output logic              host_req_ready,
    input  logic              host_req_write,
    input  logic [ADDR_W-1:0] host_req_addr,
    input  logic [DATA_W-1:0] host_req_wdata,
    output logic              host_rsp_valid,
    output logic [DATA_W-1:0] host_rsp_rdata,
    output logic              dn_req,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic              dn_ack,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic              dn_err,
    input  logic              stat_clear,
    output logic [STAT_W-1:0] stat_word
);
    br_state_e         state_q, state_d;
    logic [IDX_W-1:0]  idx_in, idx_q;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              misaligned;
    logic              loc_hit;
    logic [DATA_W-1:0] loc_rdata;
    logic              set_done, set_fail;
    logic              accept;

    assign idx_in     = host_req_addr[ADDR_W-1:3];
    assign misaligned = (host_req_addr[2:0] != 3'b000);
    assign accept     = (state_q == ST_IDLE) && host_req_valid;

    scan_local_filter #(.CHIP_ID_VAL(CHIP_ID_VAL)) filter_i (
        .idx_i   (idx_in),
        .write_i (host_req_write),
        .hit_o   (loc_hit),
        .rdata_o (loc_rdata)
    );

    scan_status_word status_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (stat_clear),
        .set_done_i (set_done),
        .set_fail_i (set_fail),
        .stat_o     (stat_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and completion events
    always_comb begin
        state_d  = state_q;
        set_done = 1'b0;
        set_fail = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (host_req_valid) begin
                    if (misaligned) begin
                        state_d  = ST_RESP;
                        set_done = 1'b1;
                        set_fail = 1'b1;
                    end else if (loc_hit) begin
                        state_d  = ST_RESP;
                        set_done = 1'b1;
                    end else begin
                        state_d = ST_FWD;
                    end
                end
            end
            ST_FWD: begin
                if (dn_ack) begin
                    state_d  = ST_RESP;
                    set_done = 1'b1;
                    set_fail = dn_err;
                end
            end
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // request capture and response data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else if (accept) begin
            idx_q   <= idx_in;
            wr_q    <= host_req_write;
            wdata_q <= host_req_wdata;
            rdata_q <= (misaligned || host_req_write) ? '0 : loc_rdata;
        end else if (state_q == ST_FWD && dn_ack) begin
            rdata_q <= (dn_err || wr_q) ? '0 : dn_rdata;
        end
    end

    // outputs
    always_comb begin
        host_req_ready = (state_q == ST_IDLE);
        host_rsp_valid = (state_q == ST_RESP);
        dn_req         = (state_q == ST_FWD);
        dn_write       = wr_q;
        dn_addr        = {idx_q, 3'b000};
        dn_wdata       = wdata_q;
        host_rsp_rdata = rdata_q;
    end

    // R5
    fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_ack) |=> (dn_req && $stable(dn_addr)));
    // R11
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req || host_rsp_valid) |-> !host_req_ready);
    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rsp_valid |=> !host_rsp_valid);
    // R8
    misalign_nofwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req_ready && host_req_valid && misaligned) |=> (!dn_req && host_rsp_valid));
    // R3
    local_nofwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req_ready && host_req_valid && loc_hit) |=> !dn_req);
    // R7
    fail_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_ack && dn_err) |=> (stat_word == 2'b11 && host_rsp_rdata == '0));
endmodule

// File: tb/scan_bridge_tb_top.sv
module scan_bridge_tb_top;
    localparam logic [63:0] CHIP = 64'h5A5A_0F0F_1234_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req_valid = 1'b0;
    logic        host_req_ready;
    logic        host_req_write = 1'b0;
    logic [34:0] host_req_addr = '0;
    logic [63:0] host_req_wdata = '0;
    logic        host_rsp_valid;
    logic [63:0] host_rsp_rdata;
    logic        dn_req, dn_write;
    logic [34:0] dn_addr;
    logic [63:0] dn_wdata;
    logic        dn_ack = 1'b0;
    logic [63:0] dn_rdata = '0;
    logic        dn_err = 1'b0;
    logic        stat_clear = 1'b0;
    logic [1:0]  stat_word;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    scan_bridge #(.CHIP_ID_VAL(CHIP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
        .host_req_write(host_req_write), .host_req_addr(host_req_addr),
        .host_req_wdata(host_req_wdata), .host_rsp_valid(host_rsp_valid),
        .host_rsp_rdata(host_rsp_rdata), .dn_req(dn_req), .dn_write(dn_write),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_ack(dn_ack),
        .dn_rdata(dn_rdata), .dn_err(dn_err), .stat_clear(stat_clear),
        .stat_word(stat_word)
    );

    task automatic check(input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic pulse_clear(input string rq);
        @(negedge clk); stat_clear = 1'b1;
        @(negedge clk); stat_clear = 1'b0;
        check(rq, "status after clear", 64'(stat_word), 64'd0);
    endtask

    task automatic access(input string rq, input logic wr, input logic [34:0] a,
                          input logic [63:0] wd, input bit fwd, input int dly,
                          input logic [63:0] drd, input bit derr,
                          input logic [63:0] exp_rd, input logic [1:0] exp_st);
        @(negedge clk);
        host_req_valid = 1'b1; host_req_write = wr;
        host_req_addr = a; host_req_wdata = wd;
        @(negedge clk);
        host_req_valid = 1'b0;
        if (fwd) begin
            check(rq, "dn_req", 64'(dn_req), 64'd1);
            check(rq, "dn_addr", 64'(dn_addr), 64'({a[34:3], 3'b000}));
            check(rq, "dn_write", 64'(dn_write), 64'(wr));
            if (wr) check(rq, "dn_wdata", dn_wdata, wd);
            check(rq, "ready busy", 64'(host_req_ready), 64'd0);
            for (int i = 0; i < dly; i++) @(negedge clk);
            check(rq, "dn_req held", 64'(dn_req), 64'd1);
            check(rq, "dn_addr held", 64'(dn_addr), 64'({a[34:3], 3'b000}));
            dn_ack = 1'b1; dn_rdata = drd; dn_err = derr;
            @(negedge clk);
            dn_ack = 1'b0; dn_err = 1'b0; dn_rdata = '0;
        end else begin
            check(rq, "not forwarded", 64'(dn_req), 64'd0);
        end
        check(rq, "rsp_valid", 64'(host_rsp_valid), 64'd1);
        check(rq, "rdata", host_rsp_rdata, exp_rd);
        check(rq, "status", 64'(stat_word), 64'(exp_st));
        @(negedge clk);
        check(rq, "rsp pulse ends", 64'(host_rsp_valid), 64'd0);
        check(rq, "ready again", 64'(host_req_ready), 64'd1);
    endtask

    function automatic logic [34:0] ia(input logic [31:0] idx);
        return {idx, 3'b000};
    endfunction

    // R12
    task automatic t_reset;
        check("R12", "stat_word", 64'(stat_word), 64'd0);
        check("R12", "ready", 64'(host_req_ready), 64'd1);
        check("R12", "rsp_valid", 64'(host_rsp_valid), 64'd0);
        check("R12", "dn_req", 64'(dn_req), 64'd0);
    endtask

    // R2, R4
    task automatic t_chip_id;
        pulse_clear("R10");
        access("R2", 1'b0, ia(32'h000F_000F), '0, 0, 0, '0, 0, CHIP, 2'b01);
        access("R4", 1'b1, ia(32'h000F_000F), 64'hDEAD, 0, 0, '0, 0, 64'd0, 2'b01);
        access("R4", 1'b0, ia(32'h000F_000F), '0, 0, 0, '0, 0, CHIP, 2'b01);
    endtask

    // R3
    task automatic t_read_zero;
        pulse_clear("R10");
        access("R3", 1'b0, ia(32'h0001_8002), '0, 0, 0, '0, 0, 64'd0, 2'b01);
        access("R3", 1'b0, ia(32'h0102_0014), '0, 0, 0, '0, 0, 64'd0, 2'b01);
        access("R3", 1'b0, ia(32'h0401_0842), '0, 0, 0, '0, 0, 64'd0, 2'b01);
        access("R3", 1'b0, ia(32'h0201_3F05), '0, 0, 0, '0, 0, 64'd0, 2'b01);
    endtask

    // R4
    task automatic t_write_absorb;
        pulse_clear("R10");
        access("R4", 1'b1, ia(32'h0101_0C04), 64'h11, 0, 0, '0, 0, 64'd0, 2'b01);
        access("R4", 1'b1, ia(32'h0202_000F), 64'h22, 0, 0, '0, 0, 64'd0, 2'b01);
        access("R4", 1'b1, ia(32'h000F_0033), 64'h33, 0, 0, '0, 0, 64'd0, 2'b01);
    endtask

    // R1, R5, R6
    task automatic t_forward;
        pulse_clear("R10");
        access("R6", 1'b0, ia(32'h0123_4567), '0, 1, 3, 64'hCAFE_F00D_0102_0304, 0,
               64'hCAFE_F00D_0102_0304, 2'b01);
        access("R5", 1'b0, ia(32'h0101_0C01), '0, 1, 0, 64'h77, 0, 64'h77, 2'b01);
        access("R5", 1'b1, ia(32'h0001_8002), 64'hAB, 1, 2, 64'hFF, 0, 64'd0, 2'b01);
        access("R1", 1'b1, ia(32'hFFFF_FFF0), 64'h8877_6655_4433_2211, 1, 1, '0, 0,
               64'd0, 2'b01);
    endtask

    // R7, R9
    task automatic t_error;
        pulse_clear("R10");
        access("R7", 1'b0, ia(32'h0300_0001), '0, 1, 1, 64'h1234, 1, 64'd0, 2'b11);
        access("R9", 1'b0, ia(32'h000F_000F), '0, 0, 0, '0, 0, CHIP, 2'b11);
        pulse_clear("R10");
        access("R7", 1'b1, ia(32'h0300_0002), 64'h5, 1, 0, '0, 1, 64'd0, 2'b11);
    endtask

    // R8
    task automatic t_misaligned;
        pulse_clear("R10");
        access("R8", 1'b0, {32'h000F_000F, 3'b100}, '0, 0, 0, '0, 0, 64'd0, 2'b11);
        pulse_clear("R10");
        access("R8", 1'b1, {32'h0300_0000, 3'b001}, 64'h9, 0, 0, '0, 0, 64'd0, 2'b11);
    endtask

    // R10: a clear in the same cycle as a completion keeps the new bits
    task automatic t_clear_race;
        pulse_clear("R10");
        access("R10", 1'b0, {32'h0, 3'b010}, '0, 0, 0, '0, 0, 64'd0, 2'b11);
        @(negedge clk);
        host_req_valid = 1'b1; host_req_write = 1'b0;
        host_req_addr = ia(32'h0001_8002); stat_clear = 1'b1;
        @(negedge clk);
        host_req_valid = 1'b0; stat_clear = 1'b0;
        check("R10", "set wins over clear", 64'(stat_word), 64'd1);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done_flag) begin
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_chip_id();
        t_read_zero();
        t_write_absorb();
        t_forward();
        t_error();
        t_misaligned();
        t_clear_race();
        done_flag = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule